// File: doc/BRIEF.md
# Fully Associative Address-Translation Cache

This block keeps a small set of recent virtual-to-physical page mappings and resolves a lookup in the same cycle. Each slot holds a page number, a frame number, three permission bits (read, write, execute), an address-space tag and a slot-occupied flag. A lookup presents a virtual address, the current address-space tag and an access kind. The block compares all slots at once and reports one of three results: a permitted hit with the physical address, a permission fault, or a miss.

A miss handler outside the block walks the page table and writes the result back through the insert port. The new mapping goes into a free slot if one exists. Otherwise it replaces the slot that was used least recently. A context switch can either empty the whole cache or drop only the slots tagged with one address space. The page walk itself, memory traffic and exception delivery stay outside the block.

Top module: `tlb_fa`

## Requirements
- R1: After reset every slot is empty, so every lookup returns `lk_hit`=0, `lk_fault`=0 and `lk_paddr`=0.
- R2: Suppose `lk_valid`=1 and an occupied slot holds the page number `lk_vaddr[VA_W-1:OFF_W]` and the tag `lk_asid`. If that slot permits the access, `lk_hit`=1 in the same cycle and `lk_paddr` = {slot frame, `lk_vaddr[OFF_W-1:0]`}.
- R3: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. `lk_acc` selects the access: 2'b00 read, 2'b01 write, 2'b10 fetch. The code 2'b11 is never permitted. A matching slot that does not permit the access gives `lk_fault`=1, `lk_hit`=0 and `lk_paddr`=0.
- R4: A slot whose tag differs from `lk_asid` never matches. The same page number can be held at once under several tags, each with its own frame.
- R5: When no slot matches the insert, an insert goes into the lowest-numbered empty slot if there is one. It is visible to lookups from the next cycle.
- R6: An insert whose page number and tag equal those of an occupied slot overwrites that slot. No duplicate is created.
- R7: When all slots are full, an insert replaces the least recently used slot. Only an insert or a permitted hit counts as a use. If both happen in the same cycle, only the insert counts. A fault and an idle lookup leave the order unchanged. Cycles that carry any flush update no order.
- R8: `flush_all` empties every slot at the clock edge. An insert in the same cycle is dropped.
- R9: `flush_asid_en` empties only the slots tagged `flush_asid` and keeps all others. An insert in the same cycle is dropped. `flush_all` takes priority when both are set.
- R10: With `lk_valid`=0, all three lookup outputs are 0, whatever the cache holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address-space tag of the requester |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| lk_hit | output | 1 | Permitted translation found |
| lk_fault | output | 1 | Mapping found but access not permitted |
| lk_paddr | output | PFN_W+OFF_W | Physical address on a hit, else 0 |
| ins_en | input | 1 | Insert request from the miss handler |
| ins_vpn | input | VA_W-OFF_W | Page number to insert |
| ins_asid | input | ASID_W | Tag of the inserted mapping |
| ins_pfn | input | PFN_W | Frame number to insert |
| ins_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| flush_all | input | 1 | Empty every slot |
| flush_asid_en | input | 1 | Empty slots of one tag |
| flush_asid | input | ASID_W | Tag to empty |

## Verification
Every wrong internal state shows up first as a wrong result on a later lookup. A corrupted recency order does nothing at the ports until the cache is full and an insert evicts the wrong slot. The error then appears on the next lookup of either the evicted mapping or the one that should have gone. For that reason the bench fills the cache and then sweeps every page and tag. A stale occupied flag or a missed partial flush shows up on the first lookup after the flush edge. A bad overwrite or slot selection shows up on the first lookup of the affected page.

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int VA_W    = 8,
  parameter int OFF_W   = 4,
  parameter int PFN_W   = 4,
  parameter int ASID_W  = 4,
  parameter int ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [VA_W-1:0]        lk_vaddr,
  input  logic [ASID_W-1:0]      lk_asid,
  input  logic [1:0]             lk_acc,
  output logic                   lk_hit,
  output logic                   lk_fault,
  output logic [PFN_W+OFF_W-1:0] lk_paddr,
  input  logic                   ins_en,
  input  logic [VA_W-OFF_W-1:0]  ins_vpn,
  input  logic [ASID_W-1:0]      ins_asid,
  input  logic [PFN_W-1:0]       ins_pfn,
  input  logic [2:0]             ins_perm,
  input  logic                   flush_all,
  input  logic                   flush_asid_en,
  input  logic [ASID_W-1:0]      flush_asid
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [2:0]         perm_q [ENTRIES];
  logic [AGE_W-1:0]   age_q  [ENTRIES];

  logic [ENTRIES-1:0] lk_match, ins_match, oldest;
  logic               hit_any, allowed, ins_go, touch_en;
  logic [AGE_W-1:0]   hit_idx, ins_idx, touch_idx;
  logic [PFN_W-1:0]   hit_pfn;
  logic [2:0]         hit_perm;

  wire [VPN_W-1:0] lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i]  = vld[i] && vpn_q[i] == lk_vpn  && asid_q[i] == lk_asid;
    assign ins_match[i] = vld[i] && vpn_q[i] == ins_vpn && asid_q[i] == ins_asid;
    assign oldest[i]    = age_q[i] == OLDEST;
  end

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    hit_pfn  = '0;
    hit_perm = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) begin
        hit_any  = 1'b1;
        hit_idx  = AGE_W'(i);
        hit_pfn  = pfn_q[i];
        hit_perm = perm_q[i];
      end
  end

  always_comb begin
    ins_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (oldest[i]) ins_idx = AGE_W'(i);
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) ins_idx = AGE_W'(i);
    for (int i = 0; i < ENTRIES; i++)
      if (ins_match[i]) ins_idx = AGE_W'(i);
  end

  always_comb begin
    case (lk_acc)
      2'd0:    allowed = hit_perm[0];
      2'd1:    allowed = hit_perm[1];
      2'd2:    allowed = hit_perm[2];
      default: allowed = 1'b0;
    endcase
  end

  assign lk_hit    = lk_valid && hit_any && allowed;
  assign lk_fault  = lk_valid && hit_any && !allowed;
  assign lk_paddr  = lk_hit ? {hit_pfn, lk_vaddr[OFF_W-1:0]} : '0;

  assign ins_go    = ins_en && !flush_all && !flush_asid_en;
  assign touch_en  = ins_go || (lk_hit && !flush_all && !flush_asid_en);
  assign touch_idx = ins_go ? ins_idx : hit_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        asid_q[i] <= '0;
        pfn_q[i]  <= '0;
        perm_q[i] <= '0;
        age_q[i]  <= AGE_W'(i);
      end
    end else begin
      if (flush_all) begin
        vld <= '0;
      end else if (flush_asid_en) begin
        for (int i = 0; i < ENTRIES; i++)
          if (asid_q[i] == flush_asid) vld[i] <= 1'b0;
      end else if (ins_go) begin
        vld[ins_idx]    <= 1'b1;
        vpn_q[ins_idx]  <= ins_vpn;
        asid_q[ins_idx] <= ins_asid;
        pfn_q[ins_idx]  <= ins_pfn;
        perm_q[ins_idx] <= ins_perm;
      end
      if (touch_en)
        for (int i = 0; i < ENTRIES; i++)
          if (AGE_W'(i) == touch_idx)          age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
    end
  end

  assert_hit_xor_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_fault));

  assert_no_duplicate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  assert_single_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_hit && !lk_fault);

  assert_insert_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_go |=> !(lk_valid && lk_vpn == $past(ins_vpn) && lk_asid == $past(ins_asid))
               || lk_hit || lk_fault);

  assert_tag_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_asid_en && !flush_all) |=> !(lk_asid == $past(flush_asid) && (lk_hit || lk_fault)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_hit && !lk_fault && lk_paddr == '0);
endmodule

// File: tb/tlb_fa_tb_top.sv
module tlb_fa_tb_top;
  localparam int VA_W = 8, OFF_W = 4, PFN_W = 4, ASID_W = 4, N = 8;
  localparam int PA_W = PFN_W + OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_hit, lk_fault;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic [ASID_W-1:0] lk_asid = '0, ins_asid = '0, flush_asid = '0;
  logic [1:0] lk_acc = '0;
  logic [PA_W-1:0] lk_paddr;
  logic ins_en = 0, flush_all = 0, flush_asid_en = 0;
  logic [VA_W-OFF_W-1:0] ins_vpn = '0;
  logic [PFN_W-1:0] ins_pfn = '0;
  logic [2:0] ins_perm = '0;

  tlb_fa #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .ASID_W(ASID_W), .ENTRIES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
    .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_asid(ins_asid), .ins_pfn(ins_pfn),
    .ins_perm(ins_perm), .flush_all(flush_all), .flush_asid_en(flush_asid_en),
    .flush_asid(flush_asid));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  string req = "R1";
  bit mv[N];
  int mvpn[N], masid[N], mpfn[N], mperm[N];
  int q[$];

  function automatic void touch(int k);
    foreach (q[j]) if (q[j] == k) begin q.delete(j); break; end
    q.push_front(k);
  endfunction

  task automatic check(string r, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic cyc();
    int m, eh, ef, ep, allow;
    #2;
    m = -1; eh = 0; ef = 0; ep = 0;
    if (lk_valid) begin
      for (int i = 0; i < N; i++)
        if (mv[i] && mvpn[i] == int'(lk_vaddr) >> OFF_W && masid[i] == int'(lk_asid)) m = i;
      if (m >= 0) begin
        allow = (lk_acc == 0) ? mperm[m] & 1 : (lk_acc == 1) ? (mperm[m] >> 1) & 1 :
                (lk_acc == 2) ? (mperm[m] >> 2) & 1 : 0;
        eh = allow; ef = !allow;
        if (allow) ep = (mpfn[m] << OFF_W) | (int'(lk_vaddr) & ((1 << OFF_W) - 1));
      end
    end
    check(req, "hit", int'(lk_hit), eh);
    check(req, "fault", int'(lk_fault), ef);
    check(req, "paddr", int'(lk_paddr), ep);
    @(posedge clk);
    if (flush_all) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
    end else if (flush_asid_en) begin
      for (int i = 0; i < N; i++) if (masid[i] == int'(flush_asid)) mv[i] = 0;
    end else if (ins_en) begin
      int v = -1;
      for (int i = N - 1; i >= 0; i--) if (!mv[i]) v = i;
      if (v < 0) v = q[$];
      for (int i = 0; i < N; i++)
        if (mv[i] && mvpn[i] == int'(ins_vpn) && masid[i] == int'(ins_asid)) v = i;
      mv[v] = 1; mvpn[v] = ins_vpn; masid[v] = ins_asid; mpfn[v] = ins_pfn; mperm[v] = ins_perm;
      touch(v);
    end else if (eh) touch(m);
    @(negedge clk);
  endtask

  task automatic idle();
    lk_valid = 0; ins_en = 0; flush_all = 0; flush_asid_en = 0;
  endtask

  task automatic look(int va, int asid, int acc);
    idle(); lk_valid = 1; lk_vaddr = VA_W'(va); lk_asid = ASID_W'(asid); lk_acc = 2'(acc); cyc();
  endtask

  task automatic put(int vpn, int asid, int pfn, int perm);
    idle(); ins_en = 1; ins_vpn = (VA_W-OFF_W)'(vpn); ins_asid = ASID_W'(asid);
    ins_pfn = PFN_W'(pfn); ins_perm = 3'(perm); cyc();
  endtask

  task automatic sweep();
    for (int a = 0; a < 3; a++)
      for (int v = 0; v < (1 << (VA_W - OFF_W)); v++) look((v << OFF_W) | 5, a, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mv[i] = 0; q.push_back(i); end
    repeat (3) @(negedge clk);
    rst_n = 1;
    req = "R1"; look(8'h35, 0, 0); look(8'h00, 1, 1); look(8'hFF, 2, 2);
    req = "R2"; put(3, 0, 9, 7); put(4, 0, 2, 1); put(5, 0, 12, 4);
    look(8'h3A, 0, 0); look(8'h3F, 0, 1); look(8'h41, 0, 0); look(8'h5C, 0, 2);
    req = "R3"; look(8'h41, 0, 1); look(8'h42, 0, 2); look(8'h5C, 0, 0); look(8'h3A, 0, 3);
    req = "R4"; put(3, 1, 6, 7); look(8'h37, 1, 0); look(8'h37, 0, 0); look(8'h37, 2, 0);
    req = "R6"; put(3, 0, 11, 2); look(8'h37, 0, 1); look(8'h37, 0, 0); look(8'h37, 1, 0);
    req = "R5"; put(7, 2, 1, 7); look(8'h70, 2, 2);
    req = "R7";
    for (int v = 8; v < 12; v++) put(v, 1, v, 7);
    look(8'h30, 0, 1); look(8'h41, 0, 1); look(8'h80, 1, 0);
    put(13, 0, 3, 7); put(14, 0, 4, 7); put(15, 2, 5, 7);
    sweep();
    req = "R9"; idle(); flush_asid_en = 1; flush_asid = 0; ins_en = 1; ins_vpn = 1; ins_asid = 1; cyc();
    sweep(); put(1, 2, 8, 7); look(8'h11, 2, 0);
    req = "R8"; idle(); flush_all = 1; flush_asid_en = 1; ins_en = 1; ins_vpn = 2; cyc();
    sweep();
    req = "R10"; put(6, 0, 10, 7); idle(); lk_vaddr = 8'h63; lk_asid = 0; cyc(); look(8'h63, 0, 0);
    req = "R7";
    for (int k = 0; k < 2000; k++) begin
      int r = $urandom_range(0, 99);
      idle();
      lk_valid = $urandom_range(0, 3) != 0;
      lk_vaddr = VA_W'($urandom_range(0, 255)); lk_asid = ASID_W'($urandom_range(0, 2));
      lk_acc = 2'($urandom_range(0, 3));
      ins_en = r < 30; ins_vpn = (VA_W-OFF_W)'($urandom_range(0, 15));
      ins_asid = ASID_W'($urandom_range(0, 2)); ins_pfn = PFN_W'($urandom_range(0, 15));
      ins_perm = 3'($urandom_range(0, 7));
      flush_all = r == 99; flush_asid_en = r == 98 || r == 97;
      flush_asid = ASID_W'($urandom_range(0, 2));
      cyc();
    end
    idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule